// File: doc/BRIEF.md
# Mode-Selectable Serial Baud Tick Generator

This block derives the timing strobes of a serial port from the system clock. A divisor counter divides the clock by (divisor + 1) and gives an oversample strobe for the receiver's data recovery. A second counter divides that strobe by a multiplier of 4, 16 or 64 and gives the per-bit strobe. The divisor is either the low byte alone or the high and low bytes taken together.

Three mode inputs set the multiplier and the divisor width: synchronous operation, high-speed operation and wide (16-bit) divisor. The bit period is the clock period times the multiplier times (divisor + 1). A write strobe restarts both counters from the current divisor, so a new rate applies at once. While the port enable is low, both counters stay at their start point and neither strobe fires.

Top module: `baud_tick_gen`

## Requirements
- R1: `os_tick` is a one-cycle pulse. It repeats every D+1 clocks, where D is the effective divisor.
- R2: `bit_tick` pulses on every M-th `os_tick`, on the same cycle as that `os_tick`, so its period is M*(D+1) clocks.
- R3: With `sync_mode`=1, M=4 whatever `high_speed` and `wide_div` are.
- R4: With `sync_mode`=0, `high_speed`=1 and `wide_div`=1, M=4.
- R5: With `sync_mode`=0 and exactly one of `high_speed` and `wide_div` set, M=16.
- R6: With `sync_mode`=0, `high_speed`=0 and `wide_div`=0, M=64.
- R7: With `wide_div`=0, D equals `div_lo` and `div_hi` has no effect on either strobe.
- R8: With `wide_div`=1, D = `div_hi`*256 + `div_lo`.
- R9: When `div_wr` is high on an edge, both counters restart from the current inputs. The first `os_tick` then comes D+1 edges later, and the first `bit_tick` comes M*(D+1) edges later.
- R10: With D=0, `os_tick` is high on every enabled cycle after the restart.
- R11: While `enable`=0, both strobes stay low and both counters hold at their start point. Once `enable` goes high, the first `os_tick` comes on the (D+1)-th enabled edge.
- R12: When `rst_n` is low on an edge, both strobes are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Serial port enable; when low, the counters hold |
| sync_mode | input | 1 | Synchronous operation select |
| high_speed | input | 1 | High-speed select |
| wide_div | input | 1 | 16-bit divisor select |
| div_hi | input | BYTE_W | Divisor high byte |
| div_lo | input | BYTE_W | Divisor low byte |
| div_wr | input | 1 | Divisor write strobe; restarts both counters |
| os_tick | output | 1 | Oversample strobe, one per divisor period |
| bit_tick | output | 1 | Bit strobe, one per M oversample strobes |

## Verification
Both strobes come from registers. After the edge on which a restart is seen (reset, `enable` low or `div_wr`), the first `os_tick` is due after the (D+1)-th following edge and the first `bit_tick` after the M*(D+1)-th. The bench model counts the enabled edges since the last restart. On each rising edge it derives the expected value of both strobes from that count, the D latched at the restart and the M decoded at the restart. It compares them with the outputs on the next falling edge, so every cycle is checked exactly where the registered value is stable. Mode and divisor changes are only applied together with `div_wr` or while the port is disabled, so the model's latched D and M always match the values the design is counting with.

// File: rtl/baud_pkg.sv
// Shared definitions for the baud tick generator.
// Assumes a multiplier of at most 64, so a 6-bit count is enough.
package baud_pkg;
    localparam int MULT_W = 6;

    // Returns the last oversample count index (multiplier - 1) for a mode set.
    function automatic logic [MULT_W-1:0] mult_last(input logic sync_sel,
                                                    input logic hs_sel,
                                                    input logic wide_sel);
        if (sync_sel)                 return MULT_W'(3);
        else if (hs_sel && wide_sel)  return MULT_W'(3);
        else if (hs_sel ^ wide_sel)   return MULT_W'(15);
        else                          return MULT_W'(63);
    endfunction
endpackage

// File: rtl/baud_mode_dec.sv
// Decodes the three mode bits into the oversample count limit, and builds
// the effective divisor from the two bytes. Purely combinational.
// Assumes the two byte inputs are held stable by the register owner.
module baud_mode_dec
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              sync_sel,
    input  logic              hs_sel,
    input  logic              wide_sel,
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    output logic [MULT_W-1:0] last_idx,
    output logic [DIV_W-1:0]  div_eff
);
    // Multiplier limit from the joint mode decode.
    always_comb last_idx = mult_last(sync_sel, hs_sel, wide_sel);

    // Divisor width follows the wide select; the high byte is dropped when narrow.
    always_comb div_eff = wide_sel ? {hi_byte, lo_byte} : {{BYTE_W{1'b0}}, lo_byte};
endmodule

// File: rtl/baud_div_cnt.sv
// Down-counter that divides the clock by (div + 1). It gives a registered
// oversample strobe and a combinational wrap flag for the next stage.
// Assumes div is stable except around a restart.
module baud_div_cnt #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             wrap,
    output logic             os_pulse
);
    logic [DIV_W-1:0] cnt;

    // The count reaches zero on an enabled cycle with no restart.
    always_comb wrap = en && !restart && (cnt == '0);

    // Counts down, reloads on wrap, reset, disable or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            cnt      <= div;
            os_pulse <= 1'b0;
        end else if (cnt == '0) begin
            cnt      <= div;
            os_pulse <= 1'b1;
        end else begin
            cnt      <= cnt - 1'b1;
            os_pulse <= 1'b0;
        end
    end

    // R1: an enabled nonzero count steps down by exactly one
    a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R9: a restart loads the divisor present at the restart
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == $past(div)));
endmodule

// File: rtl/baud_os_cnt.sv
// Counts divisor wraps modulo the multiplier. It gives a registered bit
// strobe on the wrap that completes a bit period.
// Assumes last_idx changes only together with a restart or while disabled.
module baud_os_cnt
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic              wrap,
    input  logic [MULT_W-1:0] last_idx,
    output logic              bit_pulse
);
    logic [MULT_W-1:0] osc;

    // Advances on each wrap, folds at the limit and flags the bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            osc       <= '0;
            bit_pulse <= 1'b0;
        end else if (wrap) begin
            if (osc >= last_idx) begin
                osc       <= '0;
                bit_pulse <= 1'b1;
            end else begin
                osc       <= osc + 1'b1;
                bit_pulse <= 1'b0;
            end
        end else begin
            bit_pulse <= 1'b0;
        end
    end

    // R2: the count moves only when the divisor stage wraps
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart && !wrap) |=> $stable(osc));
endmodule

// File: rtl/baud_tick_gen.sv
// Top level of the baud tick generator. It ties the mode decode, the divisor
// counter and the oversample counter together.
// Assumes the mode bits change only with a divisor write or while disabled.
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sync_mode,
    input  logic              high_speed,
    input  logic              wide_div,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic              div_wr,
    output logic              os_tick,
    output logic              bit_tick
);
    localparam int DIV_W = 2 * BYTE_W;

    logic [MULT_W-1:0] last_idx;
    logic [DIV_W-1:0]  div_eff;
    logic              wrap;

    baud_mode_dec #(.BYTE_W(BYTE_W)) u_dec (
        .sync_sel (sync_mode),
        .hs_sel   (high_speed),
        .wide_sel (wide_div),
        .hi_byte  (div_hi),
        .lo_byte  (div_lo),
        .last_idx (last_idx),
        .div_eff  (div_eff)
    );

    baud_div_cnt #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .restart  (div_wr),
        .div      (div_eff),
        .wrap     (wrap),
        .os_pulse (os_tick)
    );

    baud_os_cnt u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .restart   (div_wr),
        .wrap      (wrap),
        .last_idx  (last_idx),
        .bit_pulse (bit_tick)
    );

    // R2: a bit strobe always coincides with an oversample strobe
    a_r2_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R11: a disabled port produces no strobes on the next cycle
    a_r11_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!os_tick && !bit_tick));

    // R3: synchronous mode always decodes to a multiplier of four
    a_r3_sync_mult: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |-> (last_idx == MULT_W'(3)));

    // R6: the slowest async mode decodes to sixty-four
    a_r6_slow_mult: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !high_speed && !wide_div) |-> (last_idx == MULT_W'(63)));
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       sync_mode = 1'b0;
    logic       high_speed = 1'b0;
    logic       wide_div = 1'b0;
    logic [7:0] div_hi = 8'd0;
    logic [7:0] div_lo = 8'd0;
    logic       div_wr = 1'b0;
    logic       os_tick;
    logic       bit_tick;

    int    checks = 0;
    int    fails = 0;
    string tag = "R12";

    int n_m = 0;
    int d_m = 0;
    int m_m = 64;
    bit exp_os = 1'b0;
    bit exp_bit = 1'b0;

    always #5 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sync_mode  (sync_mode),
        .high_speed (high_speed),
        .wide_div   (wide_div),
        .div_hi     (div_hi),
        .div_lo     (div_lo),
        .div_wr     (div_wr),
        .os_tick    (os_tick),
        .bit_tick   (bit_tick)
    );

    // Reference model: count edges since the last restart and derive the strobes.
    always @(posedge clk) begin
        if (!rst_n || !enable || div_wr) begin
            n_m = 0;
            d_m = wide_div ? (int'(div_hi) * 256 + int'(div_lo)) : int'(div_lo);
            if (sync_mode)                    m_m = 4;
            else if (high_speed && wide_div)  m_m = 4;
            else if (high_speed || wide_div)  m_m = 16;
            else                              m_m = 64;
            exp_os  = 1'b0;
            exp_bit = 1'b0;
        end else begin
            n_m++;
            exp_os  = (n_m % (d_m + 1)) == 0;
            exp_bit = (n_m % (m_m * (d_m + 1))) == 0;
        end
    end

    // Compare both outputs on every falling edge.
    always @(negedge clk) begin
        checks++;
        if (os_tick !== exp_os) begin
            fails++;
            $display("FAIL R1/%s os_tick: actual %b expected %b at n=%0d", tag, os_tick, exp_os, n_m);
        end
        checks++;
        if (bit_tick !== exp_bit) begin
            fails++;
            $display("FAIL R2/%s bit_tick: actual %b expected %b at n=%0d", tag, bit_tick, exp_bit, n_m);
        end
    end

    task automatic setup(input bit s, input bit h, input bit w,
                         input logic [7:0] hi, input logic [7:0] lo,
                         input int cycles, input string t);
        @(negedge clk);
        tag        = t;
        sync_mode  = s;
        high_speed = h;
        wide_div   = w;
        div_hi     = hi;
        div_lo     = lo;
        div_wr     = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n  = 1'b1;
        enable = 1'b1;
        setup(1'b0, 1'b0, 1'b0, 8'd0, 8'd2, 450, "R6");
        setup(1'b0, 1'b1, 1'b0, 8'd0, 8'd1, 120, "R5");
        setup(1'b0, 1'b0, 1'b1, 8'd0, 8'd4, 250, "R5 R8");
        setup(1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 40, "R4 R10");
        setup(1'b0, 1'b1, 1'b1, 8'd1, 8'd0, 2100, "R4 R8");
        setup(1'b1, 1'b0, 1'b0, 8'd0, 8'd3, 60, "R3");
        setup(1'b1, 1'b1, 1'b0, 8'd0, 8'd2, 40, "R3");
        setup(1'b0, 1'b0, 1'b0, 8'hFF, 8'd5, 800, "R7");
        // R9: a write in mid-count restarts the period
        setup(1'b0, 1'b1, 1'b0, 8'd0, 8'd6, 50, "R9");
        setup(1'b0, 1'b1, 1'b0, 8'd0, 8'd6, 250, "R9");
        // R11: disable, change the divisor silently, then re-enable
        @(negedge clk);
        tag    = "R11";
        enable = 1'b0;
        repeat (30) @(negedge clk);
        div_lo = 8'd3;
        repeat (5) @(negedge clk);
        enable = 1'b1;
        repeat (200) @(negedge clk);
        // R12: reset in mid-run, then run again
        tag   = "R12";
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (150) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
        $finish;
    end
endmodule